// File: doc/BRIEF.md
# Brown-out restart sequencer

This block watches the line voltage of a switching power controller through two comparator flags: one that says the line is under the stop level, and one that says it is over the start level. The start level sits above the stop level, so the two flags give hysteresis. An undervoltage has to last for a whole blanking interval before anything happens. Shorter dips, such as the valleys of full-wave rectified ripple, pass without effect. Once a brown-out trips, gate drive is withdrawn and the supply is held at its bias level until the line comes back above the start level.

Recovery depends on where the trip happened. If the controller was running, the sequencer grounds the supply capacitor for a fixed number of ticks and then requests a fresh soft-start. If the trip came while the supply capacitor was still charging for start-up, start-up is only paused. When the line returns it resumes directly, with no grounding pulse and no soft-start request.

All times are counted in clock ticks set by parameters. The current state can be read on a debug output.

Top module: `brownout_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the block is in the charge state, and drv_en, bias_hold, cap_gnd and ss_req are all low.
- R2: In the charge state, a sampled start_done moves the block to the run state. drv_en is high only in the run state.
- R3: In the charge or run state, below_stop sampled high on BLANK_TICKS consecutive clock edges trips the block into the hold state. In the hold state drv_en is low and bias_hold is high.
- R4: A run of below_stop shorter than BLANK_TICKS edges causes no trip. Any low sample restarts the count, so two short runs separated by one low sample do not add up.
- R5: The hold state is left only when above_start is sampled high. below_stop going low does not end it.
- R6: Leaving a hold that was entered from the run state with chg_phase low drives cap_gnd high for exactly GND_TICKS cycles. During those cycles st_dbg reads 3.
- R7: On the cycle right after cap_gnd falls, ss_req is high for exactly one cycle and the block is back in the charge state.
- R8: A trip taken in the charge state, or taken while chg_phase is high, is a charge-phase trip. Its recovery goes straight from hold to charge, and cap_gnd and ss_req stay low.
- R9: st_dbg encodes the state as charge = 0, run = 1, hold = 2, ground pulse = 3.
- R10: start_done has no effect outside the charge state. In particular, the hold state does not change on start_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| below_stop | input | 1 | Line is below the stop level |
| above_start | input | 1 | Line is above the start level |
| chg_phase | input | 1 | Supply capacitor is in its start-up charge phase |
| start_done | input | 1 | Start-up has completed |
| drv_en | output | 1 | Gate-drive pulse enable |
| bias_hold | output | 1 | Request to hold the supply at bias level |
| cap_gnd | output | 1 | Supply-capacitor grounding pulse |
| ss_req | output | 1 | One-cycle soft-start request |
| st_dbg | output | 2 | Current state (debug) |

## Verification
The bench holds below_stop for exactly one edge less than the blanking count. This catches an off-by-one threshold, which would trip early. It then gives two such runs separated by a single low sample, which catches a counter that fails to clear and sums the runs. After a run-state trip it counts the cap_gnd cycles and looks for ss_req on the single following cycle, so a pulse that is too long or too short, or a soft-start that is late or overlaps, shows as a wrong count or timing. Trips taken in the charge state and with chg_phase high must recover with no grounding pulse at all; a design that always grounds the capacitor would show cap_gnd. start_done pulses and the release of below_stop during hold must leave the hold state in place.

// File: rtl/brownout_seq.sv
module brownout_seq #(
  parameter int BLANK_TICKS = 2500000,
  parameter int GND_TICKS   = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_stop,
  input  logic       above_start,
  input  logic       chg_phase,
  input  logic       start_done,
  output logic       drv_en,
  output logic       bias_hold,
  output logic       cap_gnd,
  output logic       ss_req,
  output logic [1:0] st_dbg
);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int GW = $clog2(GND_TICKS + 1);
  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_TICKS - 1);
  localparam logic [GW-1:0] GND_LAST   = GW'(GND_TICKS - 1);

  typedef enum logic [1:0] {S_CHARGE = 2'd0, S_RUN = 2'd1, S_HOLD = 2'd2, S_GND = 2'd3} st_t;

  st_t           st;
  logic [BW-1:0] blank_cnt;
  logic [GW-1:0] gnd_cnt;
  logic          from_chg;
  logic          ss_q;
  logic          watching;
  logic          trip;

  assign watching = (st == S_CHARGE) || (st == S_RUN);
  assign trip     = watching && below_stop && (blank_cnt == BLANK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_CHARGE;
      blank_cnt <= '0;
      gnd_cnt   <= '0;
      from_chg  <= 1'b0;
      ss_q      <= 1'b0;
    end else begin
      ss_q      <= 1'b0;
      blank_cnt <= (watching && below_stop && !trip) ? blank_cnt + 1'b1 : '0;
      case (st)
        S_CHARGE, S_RUN: begin
          if (trip) begin
            st       <= S_HOLD;
            from_chg <= (st == S_CHARGE) || chg_phase;
          end else if (st == S_CHARGE && start_done) begin
            st <= S_RUN;
          end
        end
        S_HOLD: begin
          if (above_start) begin
            st      <= from_chg ? S_CHARGE : S_GND;
            gnd_cnt <= '0;
          end
        end
        S_GND: begin
          if (gnd_cnt == GND_LAST) begin
            st   <= S_CHARGE;
            ss_q <= 1'b1;
          end else begin
            gnd_cnt <= gnd_cnt + 1'b1;
          end
        end
        default: st <= S_CHARGE;
      endcase
    end
  end

  assign drv_en    = (st == S_RUN);
  assign bias_hold = (st == S_HOLD);
  assign cap_gnd   = (st == S_GND);
  assign ss_req    = ss_q;
  assign st_dbg    = st;

  // R3
  trip_needs_low_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_hold) |-> $past(below_stop));

  // R5
  hold_until_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_hold && !above_start) |=> bias_hold);

  // R6
  gnd_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_gnd) |-> ($past(bias_hold) && $past(above_start)));

  // R7
  ss_after_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> ($past(cap_gnd) && !cap_gnd && st_dbg == 2'd0));

  // R2
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> ($past(start_done) && $past(st_dbg) == 2'd0));
endmodule

// File: tb/brownout_seq_tb.sv
module brownout_seq_tb;
  localparam int BLANK = 8;
  localparam int GNDT  = 4;

  logic clk = 1'b0;
  logic rst_n, below_stop, above_start, chg_phase, start_done;
  logic drv_en, bias_hold, cap_gnd, ss_req;
  logic [1:0] st_dbg;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  brownout_seq #(.BLANK_TICKS(BLANK), .GND_TICKS(GNDT)) u_dut (
    .clk(clk), .rst_n(rst_n), .below_stop(below_stop), .above_start(above_start),
    .chg_phase(chg_phase), .start_done(start_done), .drv_en(drv_en),
    .bias_hold(bias_hold), .cap_gnd(cap_gnd), .ss_req(ss_req), .st_dbg(st_dbg));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_outs(input string tag, input int st, input int d, input int b, input int g, input int s);
    check({tag, " st_dbg"}, st_dbg, st);
    check({tag, " drv_en"}, drv_en, d);
    check({tag, " bias_hold"}, bias_hold, b);
    check({tag, " cap_gnd"}, cap_gnd, g);
    check({tag, " ss_req"}, ss_req, s);
  endtask

  task automatic t_reset();
    rst_n = 0; below_stop = 0; above_start = 0; chg_phase = 0; start_done = 0;
    step(3);
    check_outs("R1 in reset", 0, 0, 0, 0, 0);
    rst_n = 1;
    step(1);
    check_outs("R1 after reset R9", 0, 0, 0, 0, 0);
  endtask

  task automatic t_start();
    step(2);
    check("R2 stays charge", st_dbg, 0);
    start_done = 1; step(1); start_done = 0;
    check_outs("R2 run R9", 1, 1, 0, 0, 0);
  endtask

  task automatic t_dip();
    below_stop = 1; step(BLANK - 1); below_stop = 0; step(1);
    check("R4 short dip", st_dbg, 1);
    below_stop = 1; step(BLANK - 1); below_stop = 0; step(1);
    below_stop = 1; step(BLANK - 1); below_stop = 0; step(1);
    check("R4 split dips", st_dbg, 1);
    check("R4 drive kept", drv_en, 1);
  endtask

  task automatic t_run_trip();
    int g = 0;
    below_stop = 1; step(BLANK - 1);
    check("R3 not yet", st_dbg, 1);
    step(1);
    check_outs("R3 trip R9", 2, 0, 1, 0, 0);
    below_stop = 0; step(5);
    check("R5 hold after line ok", st_dbg, 2);
    start_done = 1; step(1); start_done = 0; step(1);
    check("R10 start_done in hold", st_dbg, 2);
    above_start = 1; step(1); above_start = 0;
    check_outs("R6 ground R9", 3, 0, 0, 1, 0);
    while (cap_gnd && g < 50) begin g++; step(1); end
    check("R6 pulse width", g, GNDT);
    check("R7 ss_req", ss_req, 1);
    check("R7 charge", st_dbg, 0);
    step(1);
    check("R7 ss one cycle", ss_req, 0);
    start_done = 1; step(1); start_done = 0;
    check("R2 rerun", st_dbg, 1);
  endtask

  task automatic t_charge_trip(input bit use_flag);
    int seen = 0;
    string tg;
    tg = use_flag ? "R8 flag" : "R8 charge";
    if (!use_flag) begin
      rst_n = 0; step(1); rst_n = 1; step(1);
    end
    chg_phase = use_flag;
    below_stop = 1; step(BLANK); below_stop = 0; chg_phase = 0;
    check({tg, " hold"}, st_dbg, 2);
    above_start = 1; step(1); above_start = 0;
    check_outs({tg, " resume"}, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      if (cap_gnd || ss_req) seen++;
      step(1);
    end
    check({tg, " no ground/ss"}, seen, 0);
    start_done = 1; step(1); start_done = 0;
    check({tg, " run"}, st_dbg, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_start();
    t_dip();
    t_run_trip();
    t_charge_trip(1'b0);
    t_charge_trip(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule